// File: doc/BRIEF.md
# Zero-Stuffing Decimating FIR Resampler

This block converts audio samples that arrive with arbitrary timing into a steady stream at a fixed output rate. Arrival times may be uneven, and the stream may stop completely. The source never has to be rate-locked to the output. Each arriving sample lands in a one-entry holding register.

A fast free-running tick runs at a fixed multiple of the output rate. On each tick the block moves the held value into a history ring and empties the register. Each arrival therefore appears exactly once on a uniform fast grid, with zeros in between.

On each output strobe a sequential multiply-accumulate engine convolves the most recent taps of that grid with a fixed lowpass impulse response. It rounds and saturates the sum and emits one 16-bit sample with a valid pulse. The ring keeps one decimation block beyond the tap window, so ticks can keep arriving while the sum is in progress. When the input halts, the grid fills with zeros and the output falls to silence. When samples return, the output follows them with no reconfiguration.

Top module: `zs_resampler`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0, and the holding register and every history entry are zero, so outputs before any arrival are 0.
- R2: An in_valid cycle overwrites the holding register with in_data; only the last arrival before a tick is used.
- R3: Each tick appends the held value to the history and clears the register, so later ticks append 0 until another arrival.
- R4: When in_valid and tick share a cycle, the tick appends the previously held value and the new sample is kept for the next tick.
- R5: The output equals the sum over k = 0..TAPS-1 of h[k]·v[n-k], where h[k] = min(k+1, TAPS-k) (TAPS = 200 by default) and v[n] is the value appended by the last tick before the strobe cycle; a tick in the strobe cycle itself counts toward the next output.
- R6: The sum is rounded as floor((sum + 64) / 128) and then saturated to the range -32768..32767.
- R7: out_valid is a single-cycle pulse raised at the TAPS-th rising edge after the edge that samples out_strobe.
- R8: With no arrivals for at least TAPS ticks, the output is exactly 0. Later arrivals are passed again with no other action.
- R9: A strobe while a convolution is in progress is ignored; the running result is neither restarted nor duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | 16 | Signed input sample |
| tick | input | 1 | Fast grid tick (DECIM per output period) |
| out_strobe | input | 1 | Start of an output period |
| out_valid | output | 1 | One-cycle pulse with a new output |
| out_data | output | 16 | Signed output sample, held between pulses |

## Verification
The hardest cases to reach from the ports are an arrival that collides with a tick and a strobe that lands mid-convolution. Random arrivals rarely line up with either. One stimulus phase therefore places arrivals exactly on tick cycles, so the register must hand over its old value while keeping the new one. Another phase issues a second strobe halfway through each convolution. Runs of full-scale input saturate the rounding stage in both directions, and a stopped phase drains the ring until the output is exactly zero.

// File: rtl/zs_pkg.sv
package zs_pkg;
  localparam int SAMPLE_W = 16;
  typedef logic signed [SAMPLE_W-1:0] sample_t;
  localparam sample_t SAMPLE_MAX = sample_t'(16'sh7FFF);
  localparam sample_t SAMPLE_MIN = sample_t'(16'sh8000);
endpackage

// File: rtl/zs_capture.sv
module zs_capture
  import zs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  sample_t in_data,
  input  logic    tick,
  output sample_t push_data
);
  sample_t hold_q, hold_d;

  // newest arrival wins; a tick without arrival empties the register
  always_comb begin
    hold_d = hold_q;
    if (in_valid)  hold_d = in_data;
    else if (tick) hold_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign push_data = hold_q;

  // R2
  arrival_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> hold_q == $past(in_data));
  // R3
  tick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !in_valid) |=> hold_q == '0);
endmodule

// File: rtl/zs_history.sv
module zs_history
  import zs_pkg::*;
#(
  parameter int DEPTH = 300,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  sample_t       push_data,
  input  logic [AW-1:0] rd_idx,
  output sample_t       rd_data,
  output logic [AW-1:0] wr_ptr
);
  sample_t       ring_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    if (tick) wr_ptr_d = (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ptr_q <= '0;
    else        wr_ptr_q <= wr_ptr_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en;
    assign wr_en = tick && (wr_ptr_q == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ring_q[g] <= '0;
      else if (wr_en) ring_q[g] <= push_data;
    end
  end

  assign rd_data = ring_q[rd_idx];
  assign wr_ptr  = wr_ptr_q;

  // R3
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(wr_ptr_q));
  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> wr_ptr_q != $past(wr_ptr_q));
endmodule

// File: rtl/zs_coef_rom.sv
module zs_coef_rom #(
  parameter int TAPS   = 200,
  parameter int COEF_W = 8,
  localparam int CW = $clog2(TAPS)
) (
  input  logic [CW-1:0]            tap,
  output logic signed [COEF_W-1:0] coef
);
  // triangular lowpass designed for the fast tick rate
  always_comb begin
    if (int'(tap) < TAPS/2) coef = COEF_W'(int'(tap) + 1);
    else                    coef = COEF_W'(TAPS - int'(tap));
  end
endmodule

// File: rtl/zs_mac.sv
module zs_mac
  import zs_pkg::*;
#(
  parameter int TAPS   = 200,
  parameter int DEPTH  = 300,
  parameter int COEF_W = 8,
  parameter int SHIFT  = 7,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(TAPS),
  localparam int PW    = SAMPLE_W + COEF_W,
  localparam int ACC_W = PW + CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [AW-1:0] base_ptr,
  input  sample_t       rd_data,
  output logic [AW-1:0] rd_idx,
  output logic          out_valid,
  output sample_t       out_data
);
  typedef logic signed [ACC_W-1:0] acc_t;

  logic                     busy_q, busy_d, vld_q, vld_d;
  logic [CW-1:0]            cnt_q, cnt_d;
  logic [AW-1:0]            base_q, base_d;
  acc_t                     acc_q, acc_d;
  sample_t                  dat_q, dat_d;
  logic signed [COEF_W-1:0] coef;
  logic signed [PW-1:0]     prod;
  logic [AW:0]              raw_idx;

  zs_coef_rom #(.TAPS(TAPS), .COEF_W(COEF_W)) i_rom (.tap(cnt_q), .coef(coef));

  // newest entry sits just below the pointer captured at the strobe
  always_comb begin
    raw_idx = (AW+1)'(base_q) + (AW+1)'(DEPTH-1) - (AW+1)'(cnt_q);
    if (raw_idx >= (AW+1)'(DEPTH)) raw_idx = raw_idx - (AW+1)'(DEPTH);
  end
  assign rd_idx = raw_idx[AW-1:0];
  assign prod   = rd_data * coef;

  function automatic sample_t round_sat(acc_t s);
    acc_t r;
    r = (s + acc_t'(1 <<< (SHIFT-1))) >>> SHIFT;
    if (r > acc_t'(SAMPLE_MAX))      return SAMPLE_MAX;
    else if (r < acc_t'(SAMPLE_MIN)) return SAMPLE_MIN;
    else                             return sample_t'(r);
  endfunction

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    base_d = base_q;
    dat_d  = dat_q;
    vld_d  = 1'b0;
    if (busy_q) begin
      acc_d = acc_q + acc_t'(prod);
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(TAPS-1)) begin
        busy_d = 1'b0;
        vld_d  = 1'b1;
        dat_d  = round_sat(acc_d);
      end
    end else if (strobe) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      acc_d  = '0;
      base_d = base_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      base_q <= '0;
      dat_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      base_q <= base_d;
      dat_q  <= dat_d;
      vld_q  <= vld_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && strobe && cnt_q != CW'(TAPS-1)) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/zs_resampler.sv
module zs_resampler
  import zs_pkg::*;
#(
  parameter int DECIM  = 100,
  parameter int TAPS   = 200,
  parameter int COEF_W = 8,
  parameter int SHIFT  = 7,
  localparam int DEPTH = TAPS + DECIM,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_data,
  input  logic                       tick,
  input  logic                       out_strobe,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_data
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  sample_t       push_data, rd_data;
  logic [AW-1:0] rd_idx, wr_ptr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  zs_capture i_capture (
    .clk(clk), .rst_n(rst_int_n), .in_valid(in_valid), .in_data(in_data),
    .tick(tick), .push_data(push_data));

  zs_history #(.DEPTH(DEPTH)) i_history (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .push_data(push_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .wr_ptr(wr_ptr));

  zs_mac #(.TAPS(TAPS), .DEPTH(DEPTH), .COEF_W(COEF_W), .SHIFT(SHIFT)) i_mac (
    .clk(clk), .rst_n(rst_int_n), .strobe(out_strobe), .base_ptr(wr_ptr),
    .rd_data(rd_data), .rd_idx(rd_idx), .out_valid(out_valid), .out_data(out_data));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (!out_valid && out_data == '0));
endmodule

// File: tb/test_zs_resampler.sv
module test_zs_resampler;
  localparam int TAPS = 200;
  localparam int TICK_DIV = 3;
  localparam int PERIOD = 300;
  localparam int HMOD = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic tick = 1'b0;
  logic out_strobe = 1'b0;
  logic out_valid;
  logic signed [15:0] out_data;

  int checks = 0, fails = 0;
  int cyc = 0;
  int hist [HMOD];
  int n_push = 0;
  int m_hold = 0;
  int busy_end = -1;
  bit pend = 0;
  int due = 0;
  int exp_val = 0;
  int last_out = 0;
  bit done = 0;

  always #2 clk = ~clk;

  zs_resampler i_zs_resampler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .tick(tick), .out_strobe(out_strobe), .out_valid(out_valid), .out_data(out_data));

  function automatic int coef_of(int k);
    return (k < TAPS/2) ? k + 1 : TAPS - k;
  endfunction

  function automatic int expected_out();
    longint s = 0;
    longint r;
    for (int k = 0; k < TAPS; k++) begin
      int idx = n_push - 1 - k;
      if (idx >= 0) s += longint'(coef_of(k)) * longint'(hist[idx % HMOD]);
    end
    r = (s + 64) >>> 7;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic report(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic step(int mode, string req);
    bit tk, sb, iv, ev;
    int dat;
    @(negedge clk);
    ev = pend && (cyc == due);
    if (out_valid !== ev) report(1'b0, "R7 R9 valid timing", int'(out_valid), int'(ev));
    if (ev) begin
      report(int'(out_data) == exp_val, req, int'(out_data), exp_val);
      last_out = int'(out_data);
      pend = 0;
    end
    tk = (cyc % TICK_DIV) == 0;
    sb = ((cyc % PERIOD) == 1) || (mode == 5 && (cyc % PERIOD) == 101);
    dat = int'($signed(16'($urandom)));
    case (mode)
      1: iv = ($urandom % 4) == 0;
      2: begin iv = 1'b1; dat = 32767; end
      6: begin iv = 1'b1; dat = -32768; end
      4: iv = tk;
      5: iv = ($urandom % 6) == 0;
      default: iv = 1'b0;
    endcase
    tick = tk;
    out_strobe = sb;
    in_valid = iv;
    in_data = 16'(dat);
    if (sb && cyc > busy_end) begin
      exp_val = expected_out();
      pend = 1;
      due = cyc + TAPS + 1;
      busy_end = cyc + TAPS;
    end
    if (tk) begin
      hist[n_push % HMOD] = m_hold;
      n_push++;
      m_hold = iv ? dat : 0;
    end else if (iv) begin
      m_hold = dat;
    end
    cyc++;
  endtask

  task automatic run_seg(int mode, int n_out, string req);
    for (int i = 0; i < n_out * PERIOD; i++) step(mode, req);
  endtask

  initial begin
    for (int i = 0; i < HMOD; i++) hist[i] = 0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    report(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    report(out_data == 16'sd0, "R1 out_data after reset", int'(out_data), 0);
    run_seg(0, 2, "R1 idle output");
    run_seg(1, 8, "R2 R3 R5 sparse random");
    run_seg(2, 3, "R6 positive saturation");
    run_seg(6, 3, "R6 negative saturation");
    run_seg(3, 3, "R8 stopped input");
    report(last_out == 0, "R8 silence after stop", last_out, 0);
    run_seg(4, 4, "R4 arrival on tick");
    run_seg(5, 4, "R8 R9 resume with mid-run strobe");
    run_seg(0, 1, "R8 drain");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule